// File: doc/BRIEF.md
# PHY Management Frame Master

This block runs single read or write transactions on the two-wire PHY management bus: a master-driven clock (MDC) and a shared data line (MDIO) with an output enable. A request is presented as a one-cycle start pulse together with a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then clocks out a whole frame on its own. MDC is derived from the system clock by a divider.

A read releases the data line after the address fields and samples the PHY's answer. If the PHY does not pull the acknowledge bit low, the frame still runs to its normal length. The 16 data bit times are clocked anyway so every PHY on the bus stays aligned to frame boundaries. The result is then reported as a failure with zeroed data. Completion is signalled by a one-cycle done strobe. The read data and the failure flag are held until the next frame completes.

Top module: `mdio_frame_master`

## Requirements
- R1: Every frame opens with 32 MDC periods during which the master drives MDIO high (output enable 1).
- R2: After the opening run, the master drives four fields, each most significant bit first, in this order: start code 01, operation code (10 = read, 01 = write), 5-bit PHY address, 5-bit register address.
- R3: A write continues with a master-driven turnaround of 10, then the 16 write data bits, most significant bit first. The output enable stays 1 for the whole write frame.
- R4: A read deasserts the output enable for the 17 bit times that follow the register address: one acknowledge bit, then 16 data bits. MDIO is sampled on each MDC rising edge. With acknowledge 0, the read data is those 16 samples, first sample in bit 15.
- R5: A read whose acknowledge sample is 1 still runs all 16 data bit times. It then reports a failure flag of 1 and read data 0.
- R6: Every frame closes with two bit times driven 0. A write frame has 66 MDC rising edges and a read frame has 65.
- R7: MDC has a period of 2*HALF_DIV system clocks and is low whenever no frame is running. MDIO changes only while MDC is low (at the falling edge that starts a bit).
- R8: Done is high for exactly one cycle after the final bit. Read data and the failure flag are valid in that cycle and do not change until the next frame completes. A write frame clears the failure flag and leaves the read data unchanged.
- R9: A start pulse that arrives while a frame is running is ignored. The running frame keeps its fields, and no second frame follows.
- R10: After reset, MDC, the output enable, done, the failure flag and the read data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a frame |
| wr_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data for a write frame |
| mdio_i | input | 1 | Sampled state of the MDIO line |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on MDIO when enabled |
| mdio_oe_o | output | 1 | MDIO output enable |
| done_o | output | 1 | One-cycle frame completion strobe |
| rdata_o | output | 16 | Data from the last acknowledged read |
| ack_fail_o | output | 1 | Last read was not acknowledged |

## Verification
The assertions assume that request fields matter only in the cycle start is accepted from idle. They also assume that mdio_i is meaningful only during the released bit times of a read. The bench keeps within this: it pulses start for one cycle, and it changes the request fields while busy only to show they are ignored. Its PHY model moves mdio_i only on MDC falling edges, so the line is settled before each rising-edge sample. Random addresses, data and acknowledge outcomes are mixed with directed cases: all-ones and all-zeros data, a failed read followed by a write, and a start pulse during a running frame.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_BITS = 16;
  localparam int PRE_BITS  = 32;
  localparam int HDR_BITS  = 4 + 2 * ADDR_W;
  localparam int TRL_BITS  = 2;
  localparam int FRAME_W   = PRE_BITS + HDR_BITS + 2 + DATA_BITS + TRL_BITS;
  localparam int IDX_W     = $clog2(FRAME_W + 1);
  localparam int ACK_IDX   = PRE_BITS + HDR_BITS;

  localparam logic [1:0] CODE_SOF = 2'b01;
  localparam logic [1:0] CODE_RD  = 2'b10;
  localparam logic [1:0] CODE_WR  = 2'b01;
  localparam logic [1:0] CODE_TA  = 2'b10;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;

  // R7: clock parked low once the sequencer stops
  assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !mdc_q);
endmodule

// File: rtl/mdio_tx_seq.sv
module mdio_tx_seq
  import mdio_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  input  logic              fall_i,
  input  logic              mdc_i,
  output logic              run_o,
  output logic              mdio_o,
  output logic              oe_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_o,
  output logic              last_fall_o,
  output logic              done_o
);
  localparam int TAIL_W = FRAME_W - PRE_BITS - HDR_BITS;

  seq_state_e         state_q, state_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [IDX_W-1:0]   idx_q, idx_d, idx_nx, last_idx;
  logic               wr_q, wr_d;
  logic               oe_q, oe_d;
  logic               done_q, done_d;
  logic               released;

  assign last_idx    = wr_q ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
  assign last_fall_o = (state_q == ST_RUN) && fall_i && (idx_q == last_idx);
  assign idx_nx      = idx_q + IDX_W'(1);
  assign released    = (idx_nx >= IDX_W'(ACK_IDX)) &&
                       (idx_nx <= IDX_W'(ACK_IDX + DATA_BITS));

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    idx_d   = idx_q;
    wr_d    = wr_q;
    oe_d    = oe_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          idx_d   = '0;
          wr_d    = wr_i;
          oe_d    = 1'b1;
          if (wr_i)
            sr_d = {{PRE_BITS{1'b1}}, CODE_SOF, CODE_WR, phy_i, reg_i,
                    CODE_TA, wdata_i, {TRL_BITS{1'b0}}};
          else
            sr_d = {{PRE_BITS{1'b1}}, CODE_SOF, CODE_RD, phy_i, reg_i,
                    {TAIL_W{1'b0}}};
        end
      end
      ST_RUN: begin
        if (fall_i) begin
          if (idx_q == last_idx) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_nx;
            sr_d  = {sr_q[FRAME_W-2:0], 1'b0};
            oe_d  = wr_q || !released;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign mdio_o = sr_q[FRAME_W-1];
  assign oe_o   = oe_q;
  assign idx_o  = idx_q;
  assign wr_o   = wr_q;
  assign done_o = done_q;

  // R3: a write never releases the line
  assert_write_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && wr_q) |-> oe_q);
  // R7: data bit held while the clock is high
  assert_mdio_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_i |-> $stable(sr_q[FRAME_W-1]));
  // R8: completion strobe lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: start while running does not retarget the frame
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && start_i) |=> $stable(wr_q));
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_master_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_i,
  input  logic                 rd_act_i,
  input  logic                 wr_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 mdio_i,
  input  logic                 last_fall_i,
  output logic [DATA_BITS-1:0] rdata_o,
  output logic                 fail_o
);
  logic                 ack_q, ack_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic [DATA_BITS-1:0] rdata_q, rdata_d;
  logic                 fail_q, fail_d;
  logic                 in_data;

  assign in_data = (idx_i >= IDX_W'(ACK_IDX + 1)) &&
                   (idx_i <= IDX_W'(ACK_IDX + DATA_BITS));

  always_comb begin
    ack_d   = ack_q;
    sh_d    = sh_q;
    rdata_d = rdata_q;
    fail_d  = fail_q;
    if (rise_i && rd_act_i) begin
      if (idx_i == IDX_W'(ACK_IDX))
        ack_d = mdio_i;
      else if (in_data)
        sh_d = {sh_q[DATA_BITS-2:0], mdio_i};
    end
    if (last_fall_i) begin
      if (wr_i) begin
        fail_d = 1'b0;
      end else begin
        fail_d  = ack_q;
        rdata_d = ack_q ? '0 : sh_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      sh_q    <= '0;
      rdata_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      ack_q   <= ack_d;
      sh_q    <= sh_d;
      rdata_q <= rdata_d;
      fail_q  <= fail_d;
    end
  end

  assign rdata_o = rdata_q;
  assign fail_o  = fail_q;

  // R8: results move only at the end of a frame
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !last_fall_i |=> ($stable(fail_q) && $stable(rdata_q)));
  // R5: failure raised only by a read frame
  assert_fail_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> !wr_i);
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_master_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        ack_fail_o
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             run, rise, fall, mdc;
  logic             wr_cur, last_fall;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  mdc_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .run_i  (run),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_tx_seq u_seq (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .start_i     (start_i),
    .wr_i        (wr_i),
    .phy_i       (phy_addr_i),
    .reg_i       (reg_addr_i),
    .wdata_i     (wdata_i),
    .fall_i      (fall),
    .mdc_i       (mdc),
    .run_o       (run),
    .mdio_o      (mdio_o),
    .oe_o        (mdio_oe_o),
    .idx_o       (idx),
    .wr_o        (wr_cur),
    .last_fall_o (last_fall),
    .done_o      (done_o)
  );

  mdio_rx_capture u_cap (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .rise_i      (rise),
    .rd_act_i    (run & ~wr_cur),
    .wr_i        (wr_cur),
    .idx_i       (idx),
    .mdio_i      (mdio_i),
    .last_fall_i (last_fall),
    .rdata_o     (rdata_o),
    .fail_o      (ack_fail_o)
  );

  assign mdc_o = mdc;
endmodule

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;
  localparam int  HALF_DIV = 2;
  localparam time CLK_NS   = 20;
  localparam time MDC_NS   = 2 * HALF_DIV * CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wr = 1'b0;
  logic [4:0]  phy = '0, rg = '0;
  logic [15:0] wd = '0;
  logic        mdio_in = 1'b1;
  logic        mdc, mdio_out, mdio_oe, done, fail;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0;
  int rise_cnt = 0, per_bad = 0, stab_bad = 0;
  time last_rise = 0;
  logic rec_d [0:127];
  logic rec_oe[0:127];
  logic cur_wr = 1'b1, cur_ack = 1'b0;
  logic [15:0] cur_data = '0;
  logic [15:0] exp_rd = '0;
  logic prev_mdc = 1'b0, prev_out = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  mdio_frame_master #(.HALF_DIV(HALF_DIV)) u_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wr_i(wr),
    .phy_addr_i(phy), .reg_addr_i(rg), .wdata_i(wd), .mdio_i(mdio_in),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .done_o(done),
    .rdata_o(rdata), .ack_fail_o(fail)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus observer and PHY model
  always @(posedge mdc) begin
    if (rise_cnt < 128) begin
      rec_d[rise_cnt]  = mdio_out;
      rec_oe[rise_cnt] = mdio_oe;
    end
    if (rise_cnt > 0 && ($time - last_rise) != MDC_NS) per_bad++;
    last_rise = $time;
    rise_cnt++;
  end

  always @(negedge mdc) begin
    if (!cur_wr && rise_cnt == 46) mdio_in = cur_ack;
    else if (!cur_wr && rise_cnt >= 47 && rise_cnt <= 62) mdio_in = cur_data[62 - rise_cnt];
    else mdio_in = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc && prev_mdc && mdio_out !== prev_out) stab_bad++;
    prev_mdc = mdc;
    prev_out = mdio_out;
  end

  task automatic run_frame(input bit w, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input bit ack_ok,
                           input logic [15:0] pdat, input bit inject);
    int cyc;
    int bad;
    logic [13:0] hdr;
    logic [17:0] tail;
    cur_wr = w; cur_ack = ack_ok ? 1'b0 : 1'b1; cur_data = pdat;
    rise_cnt = 0;
    @(negedge clk);
    start = 1'b1; wr = w; phy = p; rg = r; wd = d;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      while (rise_cnt < 30) @(negedge clk);
      start = 1'b1; wr = ~w; phy = ~p; rg = ~r; wd = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    check(done === 1'b1, "R8", "done seen", {31'd0, done}, 32'd1);
    if (!w) exp_rd = ack_ok ? pdat : 16'h0;
    check(fail === (!w && !ack_ok), w ? "R8" : (ack_ok ? "R4" : "R5"), "fail flag",
          {31'd0, fail}, {31'd0, (!w && !ack_ok)});
    check(rdata === exp_rd, w ? "R8" : (ack_ok ? "R4" : "R5"), "read data", {16'd0, rdata}, {16'd0, exp_rd});
    @(negedge clk);
    check(done === 1'b0, "R8", "done one cycle", {31'd0, done}, 32'd0);
    check(rise_cnt == (w ? 66 : 65), "R6", "rising edge count", rise_cnt, w ? 66 : 65);
    bad = 0;
    for (int i = 0; i < 32; i++) if (rec_d[i] !== 1'b1 || rec_oe[i] !== 1'b1) bad++;
    check(bad == 0, "R1", "preamble bits", bad, 0);
    hdr = {2'b01, (w ? 2'b01 : 2'b10), p, r};
    bad = 0;
    for (int i = 0; i < 14; i++) if (rec_d[32+i] !== hdr[13-i] || rec_oe[32+i] !== 1'b1) bad++;
    check(bad == 0, inject ? "R9" : "R2", "header bits", bad, 0);
    bad = 0;
    if (w) begin
      tail = {2'b10, d};
      for (int i = 0; i < 18; i++) if (rec_d[46+i] !== tail[17-i] || rec_oe[46+i] !== 1'b1) bad++;
      check(bad == 0, inject ? "R9" : "R3", "turnaround and data", bad, 0);
      for (int i = 64; i < 66; i++) if (rec_d[i] !== 1'b0 || rec_oe[i] !== 1'b1) bad++;
    end else begin
      for (int i = 46; i < 63; i++) if (rec_oe[i] !== 1'b0) bad++;
      check(bad == 0, "R4", "released bit times", bad, 0);
      for (int i = 63; i < 65; i++) if (rec_d[i] !== 1'b0 || rec_oe[i] !== 1'b1) bad++;
    end
    check(bad == 0, "R6", "closing bits", bad, 0);
    if (inject) begin
      repeat (40) @(negedge clk);
      check(rise_cnt == 66 && mdc === 1'b0, "R9", "no second frame", rise_cnt, 66);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(mdc === 1'b0 && mdio_oe === 1'b0 && done === 1'b0, "R10", "outputs in reset",
          {29'd0, mdc, mdio_oe, done}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(fail === 1'b0 && rdata === 16'h0 && mdc === 1'b0, "R10", "state after reset",
          {15'd0, fail, rdata}, 32'd0);

    run_frame(1'b1, 5'd31, 5'd0, 16'hFFFF, 1'b1, 16'h0, 1'b0);
    run_frame(1'b1, 5'd0, 5'd31, 16'h0000, 1'b1, 16'h0, 1'b0);
    run_frame(1'b0, 5'd1, 5'd2, 16'h0, 1'b1, 16'hFFFF, 1'b0);
    run_frame(1'b0, 5'd3, 5'd4, 16'h0, 1'b1, 16'h0001, 1'b0);
    run_frame(1'b0, 5'd7, 5'd9, 16'h0, 1'b0, 16'hBEEF, 1'b0);
    repeat (50) @(negedge clk);
    check(fail === 1'b1 && rdata === 16'h0, "R8", "failure held while idle",
          {15'd0, fail, rdata}, 32'h10000);
    run_frame(1'b1, 5'd5, 5'd6, 16'h1234, 1'b1, 16'h0, 1'b0);
    run_frame(1'b0, 5'd10, 5'd11, 16'h0, 1'b1, 16'h8000, 1'b0);
    run_frame(1'b1, 5'd12, 5'd13, 16'hA5C3, 1'b1, 16'h0, 1'b1);

    for (int k = 0; k < 12; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_frame(rv[0], rv[5:1], rv[10:6], rv[26:11], rv[29:27] != 3'd0,
                $urandom, 1'b0);
    end

    check(per_bad == 0, "R7", "MDC period", per_bad, 0);
    check(stab_bad == 0, "R7", "MDIO steady while MDC high", stab_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule